// File: doc/BRIEF.md
# Security Chain Path Selector Stage

This block is a single stage in a chain of hardware security functions. Each packet reaches the stage as a stream of words. The first word is a metadata word, and the packet words follow it. The metadata word carries a path mask with one bit per function. The stage checks whether its own bit is set in that mask and picks one of two routes.

- **Bit clear:** every word is forwarded untouched through a single register stage.
- **Bit set:** the stage collects the whole packet in a local buffer and forms a verdict. It then releases the packet with a rewritten metadata word.

The verdict comes from a small rule table. The table is indexed by the flow identifier that the metadata word carries, not by header fields. The stage also holds a stub inspection hook. This hook recognises plain web requests and records the request kind in a user field of the metadata word, so that software further down the chain can reuse the result. A deny verdict empties the path so that no later function acts on the packet, and it marks the packet for dropping. A pass verdict removes only this stage's own bit.

Packet words after the metadata word are never altered. Metadata word layout:

| Bits | Field |
|------|-------|
| [7:0] | Path mask; bit n belongs to function n |
| [8] | Action; 1 = drop |
| [15:12] | Flow identifier |
| [23:16] | User field |
| Others | Carried through unchanged |

Top module: `sec_path_stage`

## Requirements
- R1: When the path bit at index OWN_ID of the metadata word is 0, every word of that packet appears on the output unchanged, with its last flag, one cycle after it is accepted, as long as the output is not stalled.
- R2: When that path bit is 1, no word of the packet appears on the output until its last word has been accepted. Packets on this route hold at most DEPTH words, the metadata word included.
- R3: On a pass verdict, the emitted metadata word equals the incoming one except for two things: path bit OWN_ID is cleared, and the user field may be rewritten as stated in R6. The action bit 8 is left as it came.
- R4: On a deny verdict, the emitted metadata word has path bits [7:0] all 0 and action bit 8 set to 1. All other bits follow R3 and R6.
- R5: The verdict is deny only when the rule-table entry selected by metadata bits [15:12] is both valid and deny. An invalid entry, or a valid entry without deny, gives pass. An entry is written in one cycle through the configuration port.
- R6: The user field is bits [23:16]. It is set to 1 when the payload starts with "GET " and to 2 when it starts with "POST". This applies only when the first packet word has protocol 6 in bits [7:0] and destination port 80 in bits [31:16], and the second packet word holds the first four payload bytes, first byte in bits [31:24]. In every other case the field keeps its incoming value.
- R7: Every word after the metadata word leaves the stage with its data, last flag and order unchanged, on both routes.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R9: After reset, out_valid is 0, in_ready is 1, and every rule-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage accepts the input word |
| in_data | input | DATA_W | Input word; the first word of each packet is metadata |
| in_last | input | 1 | Marks the last word of a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Marks the last output word of a packet |
| cfg_we | input | 1 | Rule-table write strobe |
| cfg_fid | input | $clog2(RULES) | Rule-table entry to write |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_deny | input | 1 | Deny flag written to the entry |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Packet of the metadata word alone:** a design that expected a payload word would stall.
- **Packet of exactly DEPTH words:** an off-by-one buffer index would corrupt the final word.
- **Rule entry with the deny flag set but not valid:** a stage that ignored the valid flag would wrongly drop the packet.
- **Web-like payloads on the wrong port or protocol:** these show whether the user field is rewritten only for genuine requests.
- **Stalled output on the bypass route:** this exposes a register that overwrites its held word.
- **Bypassed packet that already carries the drop action:** a design that confused the two routes would rewrite a metadata word it should leave alone.

// File: rtl/sps_pkg.sv
// Shared constants and types for the path selector stage.
// Assumes 32-bit or wider stream words; metadata layout is fixed here.
package sps_pkg;
    localparam int PATH_LSB = 0;
    localparam int PATH_W   = 8;
    localparam int ACT_BIT  = 8;
    localparam int FID_LSB  = 12;
    localparam int USR_LSB  = 16;
    localparam int USR_W    = 8;

    localparam logic [7:0]  PROTO_TCP = 8'd6;
    localparam logic [15:0] WEB_PORT  = 16'd80;
    localparam logic [31:0] WORD_GET  = 32'h4745_5420;
    localparam logic [31:0] WORD_POST = 32'h504F_5354;
    localparam logic [7:0]  USR_GET   = 8'd1;
    localparam logic [7:0]  USR_POST  = 8'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BYP     = 2'd1,
        ST_COLLECT = 2'd2,
        ST_DRAIN   = 2'd3
    } stage_state_t;
endpackage

// File: rtl/sps_rule_table.sv
// Per-flow verdict table indexed by flow identifier.
// Each entry holds a valid and a deny flag; lookup is combinational.
// Assumes at most one write per cycle; reset invalidates every entry.
module sps_rule_table #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_deny,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_deny
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] deny_q;

    // Entry update from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            deny_q  <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            deny_q[wr_idx]  <= wr_deny;
        end
    end

    // Deny only when the addressed entry is valid and marked deny.
    assign rd_deny = valid_q[rd_idx] & deny_q[rd_idx];
endmodule

// File: rtl/sps_inspect.sv
// Inspection stub: notes TCP port-80 traffic from the header word and
// classifies the first payload word as a GET or POST request.
// Assumes packet word 1 is the header summary and word 2 the payload start.
module sps_inspect #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat_en,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [DATA_W-1:0] beat_data,
    output logic              user_hit,
    output logic [7:0]        user_code
);
    import sps_pkg::*;

    logic       web_q;
    logic       hit_q;
    logic [7:0] code_q;

    // Track header match, then latch the request kind from the payload.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            web_q  <= 1'b0;
            hit_q  <= 1'b0;
            code_q <= '0;
        end else if (beat_en) begin
            if (beat_idx == CNT_W'(1)) begin
                web_q <= (beat_data[7:0] == PROTO_TCP) &&
                         (beat_data[31:16] == WEB_PORT);
            end else if (beat_idx == CNT_W'(2) && web_q) begin
                if (beat_data[31:0] == WORD_GET) begin
                    hit_q  <= 1'b1;
                    code_q <= USR_GET;
                end else if (beat_data[31:0] == WORD_POST) begin
                    hit_q  <= 1'b1;
                    code_q <= USR_POST;
                end
            end
        end
    end

    assign user_hit  = hit_q;
    assign user_code = code_q;
endmodule

// File: rtl/sps_pkt_buf.sv
// Packet store: one write port, one asynchronous read port.
// Assumes the caller never writes past DEPTH words per packet.
module sps_pkt_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per accepted beat.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sec_path_stage.sv
// Path selector stage of a hardware security chain.
// Packets whose path mask lacks OWN_ID pass through one register.
// Others are buffered whole, judged by the rule table and inspection stub,
// then released with a rewritten metadata word; packet words are untouched.
// Assumes packets on the processing route hold at most DEPTH words.
module sec_path_stage #(
    parameter int DATA_W = 32,
    parameter int OWN_ID = 2,
    parameter int RULES  = 16,
    parameter int DEPTH  = 32,
    localparam int FID_W = $clog2(RULES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              cfg_we,
    input  logic [FID_W-1:0]  cfg_fid,
    input  logic              cfg_valid,
    input  logic              cfg_deny
);
    import sps_pkg::*;

    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    stage_state_t      st_q;
    logic              byp_v_q, byp_last_q;
    logic [DATA_W-1:0] byp_data_q;
    logic [DATA_W-1:0] meta_q, new_meta, buf_rd;
    logic              deny_q, rule_deny;
    logic [CNT_W-1:0]  wr_cnt_q, rd_q;
    logic              in_fire, out_fire, own_hit, byp_load, buf_we;
    logic              user_hit;
    logic [7:0]        user_code;
    logic [AW-1:0]     buf_waddr;

    assign in_fire  = in_valid & in_ready;
    assign out_fire = out_valid & out_ready;
    assign own_hit  = in_data[PATH_LSB + OWN_ID];

    // Input acceptance per state.
    always_comb begin
        case (st_q)
            ST_IDLE:    in_ready = !byp_v_q;
            ST_BYP:     in_ready = !byp_v_q || out_ready;
            ST_COLLECT: in_ready = 1'b1;
            default:    in_ready = 1'b0;
        endcase
    end

    assign byp_load  = in_fire && ((st_q == ST_IDLE && !own_hit) || st_q == ST_BYP);
    assign buf_we    = in_fire && ((st_q == ST_IDLE && own_hit) || st_q == ST_COLLECT);
    assign buf_waddr = (st_q == ST_IDLE) ? '0 : wr_cnt_q[AW-1:0];

    // Bypass register: one-cycle pass-through of foreign packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_v_q    <= 1'b0;
            byp_last_q <= 1'b0;
            byp_data_q <= '0;
        end else if (byp_load) begin
            byp_v_q    <= 1'b1;
            byp_last_q <= in_last;
            byp_data_q <= in_data;
        end else if (out_ready) begin
            byp_v_q <= 1'b0;
        end
    end

    // Route selection, collection count and drain pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            meta_q   <= '0;
            deny_q   <= 1'b0;
            wr_cnt_q <= '0;
            rd_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (in_fire) begin
                    if (own_hit) begin
                        meta_q   <= in_data;
                        deny_q   <= rule_deny;
                        wr_cnt_q <= CNT_W'(1);
                        rd_q     <= '0;
                        st_q     <= in_last ? ST_DRAIN : ST_COLLECT;
                    end else begin
                        st_q <= in_last ? ST_IDLE : ST_BYP;
                    end
                end
                ST_BYP: if (in_fire && in_last) st_q <= ST_IDLE;
                ST_COLLECT: if (in_fire) begin
                    wr_cnt_q <= wr_cnt_q + CNT_W'(1);
                    if (in_last) st_q <= ST_DRAIN;
                end
                default: if (out_fire) begin
                    rd_q <= rd_q + CNT_W'(1);
                    if (out_last) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    sps_rule_table #(.ENTRIES(RULES)) u_rules (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_fid), .wr_valid(cfg_valid), .wr_deny(cfg_deny),
        .rd_idx(in_data[FID_LSB +: FID_W]), .rd_deny(rule_deny)
    );

    sps_inspect #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_insp (
        .clk(clk), .rst_n(rst_n),
        .clear(in_fire && st_q == ST_IDLE),
        .beat_en(in_fire && st_q == ST_COLLECT),
        .beat_idx(wr_cnt_q), .beat_data(in_data),
        .user_hit(user_hit), .user_code(user_code)
    );

    sps_pkt_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(in_data),
        .rd_addr(rd_q[AW-1:0]), .rd_data(buf_rd)
    );

    // Metadata rewrite from the verdict and inspection result.
    always_comb begin
        new_meta = meta_q;
        if (deny_q) begin
            new_meta[PATH_LSB +: PATH_W] = '0;
            new_meta[ACT_BIT]            = 1'b1;
        end else begin
            new_meta[PATH_LSB + OWN_ID] = 1'b0;
        end
        if (user_hit) new_meta[USR_LSB +: USR_W] = user_code;
    end

    // Output mux between drain and bypass routes.
    always_comb begin
        if (st_q == ST_DRAIN) begin
            out_valid = 1'b1;
            out_data  = (rd_q == '0) ? new_meta : buf_rd;
            out_last  = (rd_q == wr_cnt_q - CNT_W'(1));
        end else begin
            out_valid = byp_v_q;
            out_data  = byp_data_q;
            out_last  = byp_last_q;
        end
    end
endmodule

// File: rtl/sps_chk.sv
// Checker for the path selector stage, bound to every instance.
// Observes ports plus route state and collection count.
module sps_chk #(
    parameter int DATA_W = 32,
    parameter int OWN_ID = 2,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic [1:0]        st,
    input logic [CNT_W-1:0]  wr_cnt
);
    logic sop_q;

    // Track whether the next output word starts a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) sop_q <= 1'b1;
        else if (out_valid && out_ready) sop_q <= out_last;
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R1
    byp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && st == 2'd1 |=>
            out_valid && out_data == $past(in_data) && out_last == $past(in_last));

    // R2
    hold_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == 2'd2 |-> !out_valid);

    // R2
    capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == 2'd2 && in_valid |-> wr_cnt < CNT_W'(DEPTH));

    // R3
    own_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && sop_q |-> !out_data[OWN_ID]);
endmodule

bind sec_path_stage sps_chk #(
    .DATA_W(DATA_W), .OWN_ID(OWN_ID), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))
) u_sps_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .st(st_q), .wr_cnt(wr_cnt_q)
);

// File: tb/tb_sec_path_stage.sv
module tb_sec_path_stage;
    localparam int DW = 32, OWN = 2, RULES = 16, DEPTH = 32;
    localparam logic [31:0] GETW = 32'h4745_5420, POSTW = 32'h504F_5354;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [DW-1:0] in_data = '0, out_data;
    logic out_valid, out_last, out_ready = 1'b0;
    logic cfg_we = 1'b0, cfg_valid = 1'b0, cfg_deny = 1'b0;
    logic [3:0] cfg_fid = '0;

    always #5 clk = ~clk;

    sec_path_stage #(.DATA_W(DW), .OWN_ID(OWN), .RULES(RULES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .cfg_we(cfg_we), .cfg_fid(cfg_fid), .cfg_valid(cfg_valid), .cfg_deny(cfg_deny)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, exp_wr = 0, exp_rd = 0, rdy_mode = 1;
    bit done = 1'b0;
    logic [31:0] exp_d [8192];
    logic        exp_l [8192];
    string       exp_t [8192];
    bit tbl_v [16];
    bit tbl_d [16];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Downstream ready pattern.
    always @(negedge clk) begin
        case (rdy_mode)
            0: out_ready = ($urandom % 4) != 0;
            1: out_ready = 1'b1;
            default: out_ready = 1'b0;
        endcase
    end

    // Output monitor against the expected word list.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_rd >= exp_wr) begin
                check(1'b0, "R7 unexpected word", out_data, 32'h0);
            end else begin
                check(out_data == exp_d[exp_rd] && out_last == exp_l[exp_rd],
                      exp_t[exp_rd], {out_data[30:0], out_last}, {exp_d[exp_rd][30:0], exp_l[exp_rd]});
                exp_rd++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", exp_rd, exp_wr);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] rewrite(input logic [31:0] m, input bit deny,
                                            input bit hit, input logic [7:0] code);
        logic [31:0] r = m;
        if (deny) begin
            r[7:0] = 8'h00;
            r[8]   = 1'b1;
        end else begin
            r[OWN] = 1'b0;
        end
        if (hit) r[23:16] = code;
        return r;
    endfunction

    task automatic drive_beat(input logic [31:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic cfg_rule(input int fid, input bit v, input bit d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_fid = fid[3:0]; cfg_valid = v; cfg_deny = d;
        @(negedge clk);
        cfg_we = 1'b0;
        tbl_v[fid] = v;
        tbl_d[fid] = d;
    endtask

    task automatic send_pkt(input logic [31:0] meta, input logic [7:0] proto,
                            input logic [15:0] port, input logic [31:0] pay,
                            input int nb, input bit hold_chk);
        logic [31:0] w [64];
        bit own = meta[OWN];
        int fid = int'(meta[15:12]);
        bit deny = tbl_v[fid] && tbl_d[fid];
        bit hit = own && nb >= 3 && proto == 8'd6 && port == 16'd80 &&
                  (pay == GETW || pay == POSTW);
        logic [7:0] code = (pay == GETW) ? 8'd1 : 8'd2;
        w[0] = meta;
        w[1] = {port, 8'h00, proto};
        w[2] = pay;
        for (int i = 3; i < nb; i++) w[i] = $urandom;
        exp_d[exp_wr] = own ? rewrite(meta, deny, hit, code) : meta;
        exp_l[exp_wr] = (nb == 1);
        exp_t[exp_wr] = !own ? "R1 bypass metadata" : deny ? "R4 deny rewrite" :
                        hit ? "R6 user field" : "R3 pass rewrite";
        exp_wr++;
        for (int i = 1; i < nb; i++) begin
            exp_d[exp_wr] = w[i];
            exp_l[exp_wr] = (i == nb - 1);
            exp_t[exp_wr] = "R7 packet word";
            exp_wr++;
        end
        for (int i = 0; i < nb; i++) begin
            drive_beat(w[i], i == nb - 1);
            if (hold_chk && own && i != nb - 1) begin
                @(negedge clk);
                #2;
                check(!out_valid, "R2 held until last", {31'd0, out_valid}, 32'd0);
            end
        end
    endtask

    task automatic wait_drain();
        while (exp_rd < exp_wr) @(negedge clk);
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin tbl_v[i] = 1'b0; tbl_d[i] = 1'b0; end
        repeat (3) @(negedge clk);
        #2;
        check(!out_valid, "R9 reset out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready, "R9 reset in_ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 / R5: empty table gives pass; fid 5 with deny set in metadata bits.
        send_pkt(32'h00AB_5104, 8'd17, 16'd53, 32'h1234_5678, 4, 1'b0);
        wait_drain();

        // R1 latency: word visible one cycle after acceptance.
        send_pkt(32'h0000_0103, 8'd6, 16'd80, GETW, 1, 1'b0);
        check(out_valid && out_data == 32'h0000_0103, "R1 one-cycle latency", out_data, 32'h0000_0103);
        wait_drain();

        // R4 / R2: deny entry, check nothing leaves before the last word.
        cfg_rule(3, 1'b1, 1'b1);
        send_pkt(32'h0011_30FF, 8'd6, 16'd80, GETW, 5, 1'b1);
        wait_drain();

        // R6: request kinds and non-matching traffic.
        send_pkt(32'h0055_1004, 8'd6, 16'd80, GETW, 3, 1'b0);
        send_pkt(32'h0055_1004, 8'd6, 16'd80, POSTW, 6, 1'b0);
        send_pkt(32'h0055_1004, 8'd6, 16'd443, GETW, 3, 1'b0);
        send_pkt(32'h0055_1004, 8'd17, 16'd80, POSTW, 3, 1'b0);
        send_pkt(32'h0055_1004, 8'd6, 16'd80, 32'h4745_5458, 3, 1'b0);
        send_pkt(32'h0055_1004, 8'd6, 16'd80, GETW, 2, 1'b0);
        wait_drain();

        // R5: valid without deny, and deny flag on an invalid entry.
        cfg_rule(7, 1'b1, 1'b0);
        send_pkt(32'h0000_7004, 8'd1, 16'd1, 32'h0, 3, 1'b0);
        cfg_rule(3, 1'b0, 1'b1);
        send_pkt(32'h0000_3004, 8'd1, 16'd1, 32'h0, 3, 1'b0);
        wait_drain();

        // R8: stalled output holds its word.
        rdy_mode = 2;
        send_pkt(32'hC0DE_0001, 8'd0, 16'd0, 32'h0, 1, 1'b0);
        @(negedge clk);
        #2;
        held = out_data;
        repeat (3) @(negedge clk);
        #2;
        check(out_valid && out_data == held, "R8 stall hold", out_data, held);
        rdy_mode = 0;
        wait_drain();

        // R2 boundary: full-depth processed packet, and a bypassed one carrying drop.
        cfg_rule(9, 1'b1, 1'b1);
        send_pkt(32'h0000_9004, 8'd6, 16'd80, POSTW, DEPTH, 1'b0);
        send_pkt(32'h0000_9103, 8'd6, 16'd80, POSTW, 7, 1'b0);
        wait_drain();

        // Random traffic.
        for (int p = 0; p < 150; p++) begin
            logic [31:0] m = $urandom;
            logic [7:0] pr = ($urandom % 3 == 0) ? 8'd17 : 8'd6;
            logic [15:0] pt = ($urandom % 3 == 0) ? 16'd443 : 16'd80;
            int k = $urandom % 3;
            logic [31:0] pay = (k == 0) ? GETW : (k == 1) ? POSTW : $urandom;
            int nb;
            m[OWN] = ($urandom % 2) == 0;
            nb = m[OWN] ? 1 + int'($urandom % DEPTH) : 1 + int'($urandom % 40);
            if (p % 10 == 0) cfg_rule(int'($urandom % 16), $urandom % 2 == 0, $urandom % 2 == 0);
            send_pkt(m, pr, pt, pay, nb, 1'b0);
        end
        wait_drain();
        repeat (5) @(negedge clk);
        #2;
        check(!out_valid, "R7 no extra words", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule